// File: doc/BRIEF.md
# Clock output enable sequencer

This block sits between a frequency-locked clock source and the pins that carry its output. It runs on the generated clock and passes that clock to a set of matched output copies (two by default) only when an active-low enable asks for it. The enable may arrive with no relation to any clock in the design, so it is first brought into the generated-clock domain through a chain of flops.

Once the synchronized enable is seen, the sequencer waits a settling interval before releasing the outputs. The interval is measured in reference periods, not in generated-clock cycles, and its length depends on the multiplier ratio. A strobe input marks each reference edge for one generated-clock cycle. The ratio select picks the count: the high-rate reference needs twice as many periods as the low-rate one for the same settling time. The select is captured once, when the enable takes effect. The output gate changes only on falling edges of the generated clock. Release therefore starts with a full-width high phase. On disable, the high phase in progress runs to completion before the outputs stay low.

A status flag reports whether the outputs are currently gated through. Generating the clock, and any analog output drive, are outside this block.

Top module: `clk_out_seq`

## Requirements
- R1: While the enable input `en_n` is high (inactive), every output copy and `live_o` are low from the fourth rising edge of `gen_clk` after `en_n` rises, and they stay low.
- R2: After reset the synchronizer reads the enable as inactive, so the outputs stay low until `en_n` is driven low. Reference strobes that arrive while the sequencer is off earn no credit toward the settling count.
- R3: A low level on `en_n` takes effect on the third rising edge of `gen_clk`: two synchronizer flops, then the state register. The outputs are released after exactly N strobes counted from the next edge on. N is `SETTLE_HI_RATE` when `ratio_sel` = 1 (high-rate reference) and `SETTLE_LO_RATE` when `ratio_sel` = 0. No output pulse appears before the N-th strobe.
- R4: After `en_n` rises, the high phase that starts on the third rising edge runs for its full width. The outputs are low from the next rising edge on, with no shortened pulse.
- R5: The gate opens only on a falling edge of `gen_clk`. The first output high phase starts on the rising edge that follows the edge which recorded the N-th strobe, and it lasts a full high phase. The outputs are low during every low phase of `gen_clk`.
- R6: All output copies are identical at every instant.
- R7: If `en_n` rises during the settling wait, the sequencer returns to off and discards the strobes counted so far. The next enable again needs the full N strobes.
- R8: `ratio_sel` is captured on the edge where the enable takes effect. Later changes during the wait do not change N.
- R9: `live_o` is high exactly while the outputs are gated through. It changes on the same falling edge as the gate.
- R10: A low `rst_n` forces the outputs and `live_o` low at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gen_clk | input | 1 | Generated clock; the block's clock and the source of the gated outputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe in the `gen_clk` domain marking each reference edge |
| ratio_sel | input | 1 | Multiplier select: 1 = high-rate reference (longer count), 0 = low-rate reference |
| en_n | input | 1 | Asynchronous active-low output enable |
| clk_out | output | NUM_OUTS (2) | Gated copies of `gen_clk` |
| live_o | output | 1 | High while the outputs are gated through |

## Verification
Every result follows the enable with a fixed latency. A change on `en_n` reaches the state register on the third rising edge. A strobe recorded on edge P gives the first output high phase from edge P+1, because the gate flop updates on the falling edge in between. On disable, the high phase begun on the third edge must run its full width, and the outputs must be low from the fourth edge. The bench drives all inputs 1 ns after a rising edge and samples at that same point, when the outputs follow the high phase. It takes extra samples 3 ns later to see that the phase is still full, and 5 ns later to see that the low phase is clean. Each check falls in the one cycle where the counted latency says the output changes.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

   typedef enum logic [1:0] {
      SQ_OFF    = 2'd0,
      SQ_SETTLE = 2'd1,
      SQ_LIVE   = 2'd2
   } seq_state_t;

   function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m < 1) ? 1 : $clog2(m + 1);
   endfunction

endpackage

// File: rtl/clkseq_sync.sv
module clkseq_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain;

   if (STAGES < 2) begin : g_bad_stages
      $error("clkseq_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RESET_VAL;
            else        chain[0] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RESET_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/clkseq_settle_cnt.sv
module clkseq_settle_cnt #(
   parameter int unsigned HI_COUNT = 400,
   parameter int unsigned LO_COUNT = 200,
   parameter int unsigned CNT_W    = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_i,
   input  logic             sel_i,
   input  logic             clr_i,
   input  logic             step_i,
   output logic             done_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] tgt_o
);
   localparam logic [CNT_W-1:0] HI_V = CNT_W'(HI_COUNT);
   localparam logic [CNT_W-1:0] LO_V = CNT_W'(LO_COUNT);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] tgt_q;
   logic [CNT_W-1:0] tgt_m1;

   if (HI_COUNT < 1 || LO_COUNT < 1) begin : g_bad_count
      $error("clkseq_settle_cnt: settle counts must be at least 1");
   end
   if (CNT_W < $clog2(HI_COUNT + 1) || CNT_W < $clog2(LO_COUNT + 1)) begin : g_bad_width
      $error("clkseq_settle_cnt: CNT_W too narrow for settle counts");
   end

   assign tgt_m1 = tgt_q - CNT_W'(1);
   assign done_o = step_i && (cnt_q == tgt_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tgt_q <= HI_V;
      end else if (arm_i) begin
         cnt_q <= '0;
         tgt_q <= sel_i ? HI_V : LO_V;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (step_i) begin
         cnt_q <= done_o ? '0 : cnt_q + CNT_W'(1);
      end
   end

   assign cnt_o = cnt_q;
   assign tgt_o = tgt_q;

   // R3: the count never reaches the selected target
   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < tgt_q)
      else $error("settle count out of range");
endmodule

// File: rtl/clkseq_fsm.sv
module clkseq_fsm
   import clkseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_act_i,
   input  logic       tick_i,
   input  logic       done_i,
   output seq_state_t state_o,
   output logic       arm_o,
   output logic       clr_o,
   output logic       step_o,
   output logic       run_o
);
   seq_state_t st_q, st_d;

   always_comb begin
      st_d  = st_q;
      arm_o = 1'b0;
      clr_o = 1'b0;
      unique case (st_q)
         SQ_OFF: begin
            if (en_act_i) begin
               st_d  = SQ_SETTLE;
               arm_o = 1'b1;
            end
         end
         SQ_SETTLE: begin
            if (!en_act_i) begin
               st_d  = SQ_OFF;
               clr_o = 1'b1;
            end else if (done_i) begin
               st_d = SQ_LIVE;
            end
         end
         SQ_LIVE: begin
            if (!en_act_i) st_d = SQ_OFF;
         end
         default: st_d = SQ_OFF;
      endcase
   end

   assign step_o = (st_q == SQ_SETTLE) && en_act_i && tick_i;
   assign run_o  = (st_q == SQ_LIVE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= SQ_OFF;
      else        st_q <= st_d;
   end

   assign state_o = st_q;

   // R3: the outputs are never released without passing through the wait
   p_no_direct_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SQ_LIVE) |-> ($past(st_q) != SQ_OFF))
      else $error("released without settling");

   // R1: an inactive enable always leads back to off on the next edge
   p_drop_on_disable_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_act_i && st_q != SQ_OFF) |=> (st_q == SQ_OFF))
      else $error("disable not honoured");
endmodule

// File: rtl/clkseq_gate.sv
module clkseq_gate #(
   parameter int unsigned NUM_OUTS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run_i,
   output logic [NUM_OUTS-1:0] clk_out,
   output logic                live_o
);
   logic gate_q;

   if (NUM_OUTS < 1) begin : g_bad_outs
      $error("clkseq_gate: NUM_OUTS must be at least 1");
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= run_i;
   end

   for (genvar i = 0; i < NUM_OUTS; i++) begin : g_copy
      assign clk_out[i] = clk & gate_q;
   end

   assign live_o = gate_q;

   // R5: the gate only opens when the sequencer has reached the running state
   p_live_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_q) |-> run_i)
      else $error("gate opened without run request");
endmodule

// File: rtl/clk_out_seq.sv
module clk_out_seq
   import clkseq_pkg::*;
#(
   parameter int unsigned SETTLE_HI_RATE = 400,
   parameter int unsigned SETTLE_LO_RATE = 200,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned NUM_OUTS       = 2
) (
   input  logic                gen_clk,
   input  logic                rst_n,
   input  logic                ref_tick,
   input  logic                ratio_sel,
   input  logic                en_n,
   output logic [NUM_OUTS-1:0] clk_out,
   output logic                live_o
);
   localparam int unsigned CNT_W = cnt_width(SETTLE_HI_RATE, SETTLE_LO_RATE);

   if (SETTLE_HI_RATE < 1 || SETTLE_LO_RATE < 1) begin : g_bad_settle
      $error("clk_out_seq: settle counts must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("clk_out_seq: at least two synchronizer stages required");
   end
   if (NUM_OUTS < 1) begin : g_bad_outs
      $error("clk_out_seq: at least one output copy required");
   end

   logic             en_n_sync;
   logic             en_act;
   logic             arm, clr, step, done, run;
   logic [CNT_W-1:0] cnt, tgt;
   seq_state_t       state;

   clkseq_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk     (gen_clk),
      .rst_n   (rst_n),
      .d_async (en_n),
      .q_sync  (en_n_sync)
   );

   assign en_act = ~en_n_sync;

   clkseq_fsm u_fsm (
      .clk      (gen_clk),
      .rst_n    (rst_n),
      .en_act_i (en_act),
      .tick_i   (ref_tick),
      .done_i   (done),
      .state_o  (state),
      .arm_o    (arm),
      .clr_o    (clr),
      .step_o   (step),
      .run_o    (run)
   );

   clkseq_settle_cnt #(
      .HI_COUNT (SETTLE_HI_RATE),
      .LO_COUNT (SETTLE_LO_RATE),
      .CNT_W    (CNT_W)
   ) u_cnt (
      .clk    (gen_clk),
      .rst_n  (rst_n),
      .arm_i  (arm),
      .sel_i  (ratio_sel),
      .clr_i  (clr),
      .step_i (step),
      .done_o (done),
      .cnt_o  (cnt),
      .tgt_o  (tgt)
   );

   clkseq_gate #(
      .NUM_OUTS (NUM_OUTS)
   ) u_gate (
      .clk     (gen_clk),
      .rst_n   (rst_n),
      .run_i   (run),
      .clk_out (clk_out),
      .live_o  (live_o)
   );

   // R7: whenever the sequencer is off, no settling credit is held
   p_off_cnt_clear_r7: assert property (@(posedge gen_clk) disable iff (!rst_n)
      (state == SQ_OFF) |-> (cnt == '0))
      else $error("stale settle count while off");

   // R8: the captured count target does not move during the wait
   p_target_hold_r8: assert property (@(posedge gen_clk) disable iff (!rst_n)
      (state == SQ_SETTLE && $past(state) == SQ_SETTLE) |-> $stable(tgt))
      else $error("settle target changed mid-wait");
endmodule

// File: tb/clk_out_seq_tb_top.sv
module clk_out_seq_tb_top;
   localparam int HI = 5;
   localparam int LO = 3;
   localparam int NV = 4;
   // {sel, gap[6:0]}
   localparam logic [7:0] VEC [NV] = '{8'h80, 8'h02, 8'h83, 8'h00};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_tick = 1'b0;
   logic       ratio_sel = 1'b0;
   logic       en_n = 1'b1;
   logic [1:0] clk_out;
   logic       live_o;
   int         checks = 0;
   int         errs = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   clk_out_seq #(
      .SETTLE_HI_RATE (HI),
      .SETTLE_LO_RATE (LO),
      .SYNC_STAGES    (2),
      .NUM_OUTS       (2)
   ) dut_i (
      .gen_clk   (clk),
      .rst_n     (rst_n),
      .ref_tick  (ref_tick),
      .ratio_sel (ratio_sel),
      .en_n      (en_n),
      .clk_out   (clk_out),
      .live_o    (live_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic edge1();
      @(posedge clk);
      #1;
   endtask

   task automatic tick(input int gap);
      ref_tick = 1'b1;
      edge1();
      ref_tick = 1'b0;
      repeat (gap) edge1();
   endtask

   task automatic release_seq(input logic sel, input int gap, input string req);
      int n;
      n = sel ? HI : LO;
      ratio_sel = sel;
      en_n = 1'b0;
      repeat (3) edge1();
      ratio_sel = ~sel;               // R8: late change must not alter n
      for (int k = 1; k < n; k++) begin
         tick(gap);
         chk(req, "held low before last strobe", int'(clk_out), 0);
         chk(req, "live low before last strobe", int'(live_o), 0);
      end
      ref_tick = 1'b1;
      edge1();
      ref_tick = 1'b0;
      chk("R5", "no pulse on recording edge", int'(clk_out), 0);
      edge1();
      chk(req, "released after n strobes", int'(clk_out), 3);
      chk("R9", "live after release", int'(live_o), 1);
      chk("R6", "copies match", int'(clk_out[0]), int'(clk_out[1]));
      #5;
      chk("R5", "low during low phase", int'(clk_out), 0);
      edge1();
   endtask

   task automatic disable_seq();
      en_n = 1'b1;
      repeat (3) edge1();
      chk("R4", "high phase on third edge", int'(clk_out), 3);
      #3;
      chk("R4", "high phase still full", int'(clk_out), 3);
      edge1();
      chk("R1", "outputs low after disable", int'(clk_out), 0);
      chk("R9", "live low after disable", int'(live_o), 0);
      repeat (6) edge1();
      chk("R1", "outputs stay low", int'(clk_out), 0);
   endtask

   initial begin
      #100000;
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      // reset state, R10
      en_n = 1'b0;
      repeat (4) edge1();
      chk("R10", "outputs low in reset", int'(clk_out), 0);
      chk("R10", "live low in reset", int'(live_o), 0);
      en_n = 1'b1;
      edge1();
      rst_n = 1'b1;
      // R2: default off, strobes while off ignored
      for (int k = 0; k < HI + 2; k++) tick(1);
      chk("R2", "off by default", int'(clk_out), 0);
      chk("R2", "live off by default", int'(live_o), 0);
      release_seq(1'b1, 0, "R2");
      disable_seq();

      // vector table walk, R3
      for (int v = 0; v < NV; v++) begin
         release_seq(VEC[v][7], int'(VEC[v][6:0]), "R3");
         disable_seq();
      end

      // R7: abort during wait discards credit
      ratio_sel = 1'b0;
      en_n = 1'b0;
      repeat (3) edge1();
      for (int k = 1; k < LO; k++) tick(0);
      en_n = 1'b1;
      repeat (5) edge1();
      chk("R7", "aborted wait stays low", int'(clk_out), 0);
      release_seq(1'b0, 1, "R7");
      disable_seq();

      // R8: directed capture of the select
      release_seq(1'b1, 0, "R8");
      disable_seq();

      // R10: asynchronous reset while running
      release_seq(1'b0, 0, "R3");
      #1;
      rst_n = 1'b0;
      #1;
      chk("R10", "async reset drops outputs", int'(clk_out), 0);
      chk("R10", "async reset drops live", int'(live_o), 0);
      en_n = 1'b1;
      edge1();
      rst_n = 1'b1;
      repeat (5) edge1();
      chk("R1", "low after reset with enable off", int'(clk_out), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule